// File: doc/BRIEF.md
# Tagged Circular Floating-Point Register Stack

This block holds eight 80-bit extended-format floating-point values in a circular register file. Software-visible operands are named relative to a moving 3-bit top pointer: stack slot st(n) is physical register (top + n) mod 8. Each physical register carries a 2-bit tag that records whether it is empty or, when written, what kind of value it holds. The tag is derived from the stored bits at write time.

One operation is applied per clock through a 3-bit opcode. The operations are: clear the stack, push an external value, push one of three built-in constants (1.0, pi, +0.0), pop, and read a slot. Pushing onto an occupied register and popping or reading an empty one are reported through a sticky stack-fault flag. A direction bit tells overflow from underflow. The top pointer, the fault flag and the direction bit also appear in a 16-bit status word. No arithmetic, rounding or precision handling takes place here.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset every tag is empty (tag_word = 16'hFFFF), top_ptr = 0, stack_fault = 0, cond_c1 = 0 and every data register holds zero.
- R2: status_word carries top_ptr in bits 13:11, cond_c1 in bit 9 and stack_fault in bit 6, and all other bits are 0.
- R3: Opcode 1 (clear) marks all eight registers empty, sets top_ptr to 0 and clears stack_fault and cond_c1. Register contents are left unchanged and remain visible on rd_data.
- R4: tag_word bits [2i+1:2i] hold the tag of physical register i, encoded as 00 valid, 01 zero, 10 special and 11 empty.
- R5: Opcode 2 pushes push_data. When the target register (top_ptr - 1) mod 8 is empty, the value is written there, its tag is set, and top_ptr takes the decremented value. The first push after a clear therefore lands in physical register 7.
- R6: A pushed value is tagged from its bits, where the exponent is bits 78:64 and the explicit integer bit is bit 63. An all-ones exponent gives special. A zero exponent gives zero when bits 63:0 are all 0, and special otherwise. Any other exponent gives valid when bit 63 is 1 and special when it is 0. The sign is ignored.
- R7: Opcodes 3, 4 and 5 push the constants 80'h3FFF8000000000000000 (1.0, tag valid), 80'h4000C90FDAA22168C235 (pi, tag valid) and all zeros (tag zero), following the same rules as R5.
- R8: A push of any kind whose target register is not empty sets stack_fault and sets cond_c1 to 1. Data, tags and top_ptr are left unchanged.
- R9: Opcode 6 (pop) marks register top_ptr empty and then increments top_ptr mod 8. If that register is already empty, it instead sets stack_fault with cond_c1 = 0 and changes nothing else.
- R10: rd_data always shows physical register (top_ptr + rd_idx) mod 8. Opcode 7 (read) sets stack_fault with cond_c1 = 0 when that register is empty, and otherwise changes nothing.
- R11: stack_fault stays set until a clear or reset. cond_c1 reflects the most recent fault.
- R12: Opcode 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code for this cycle |
| push_data | input | 80 | Value written by opcode 2 |
| rd_idx | input | 3 | Stack-relative slot n for rd_data and opcode 7 |
| rd_data | output | 80 | Contents of slot st(rd_idx) |
| tag_word | output | 16 | Tags of all physical registers, two bits each |
| top_ptr | output | 3 | Current top-of-stack pointer |
| stack_fault | output | 1 | Sticky stack fault flag |
| cond_c1 | output | 1 | Fault direction: 1 overflow, 0 underflow |
| status_word | output | 16 | Packed status with pointer and fault bits |

## Verification
The hardest state to reach from the ports is a completely full stack whose top pointer has wrapped through every physical register. Only in that state can an overflow fault occur and a push be refused. The stimulus pushes eight values that cover every tag class, attempts a ninth push, and then reads all eight slots. It then pops the stack back to empty and pops once more, so the direction bit flips from overflow to underflow while the fault stays set. Each cycle is compared against a behavioural model of the stack.

// File: rtl/fp_stack_pkg.sv
package fp_stack_pkg;

    parameter int FP_W      = 80;
    parameter int FP_EXP_W  = 15;
    parameter int STK_DEPTH = 8;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_CLEAR     = 3'd1,
        OP_PUSH      = 3'd2,
        OP_PUSH_ONE  = 3'd3,
        OP_PUSH_PI   = 3'd4,
        OP_PUSH_ZERO = 3'd5,
        OP_POP       = 3'd6,
        OP_READ      = 3'd7
    } stk_op_e;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } stk_tag_e;

endpackage

// File: rtl/fp_tag_classify.sv
module fp_tag_classify
    import fp_stack_pkg::*;
#(
    parameter int W     = FP_W,
    parameter int EXP_W = FP_EXP_W
) (
    input  logic [W-1:0] value_i,
    output stk_tag_e     tag_o
);
    localparam int MAN_W = W - 1 - EXP_W;

    logic [EXP_W-1:0] exp_field;
    logic [MAN_W-1:0] sig_field;
    logic             int_bit;

    assign exp_field = value_i[W-2 -: EXP_W];
    assign sig_field = value_i[MAN_W-1:0];
    assign int_bit   = value_i[MAN_W-1];

    always_comb begin
        if (&exp_field) begin
            tag_o = TAG_SPECIAL;
        end else if (exp_field == '0) begin
            tag_o = (sig_field == '0) ? TAG_ZERO : TAG_SPECIAL;
        end else begin
            tag_o = int_bit ? TAG_VALID : TAG_SPECIAL;
        end
    end
endmodule

// File: rtl/fp_preset_rom.sv
module fp_preset_rom
    import fp_stack_pkg::*;
#(
    parameter int W     = FP_W,
    parameter int EXP_W = FP_EXP_W
) (
    input  stk_op_e      op_i,
    output logic [W-1:0] const_o
);
    localparam int            MAN_W  = W - 1 - EXP_W;
    localparam logic [EXP_W-1:0] BIAS = EXP_W'((1 << (EXP_W - 1)) - 1);
    localparam logic [63:0]   PI_SIG = 64'hC90FDAA22168C235;

    logic [MAN_W-1:0] pi_man;
    logic [MAN_W-1:0] one_man;

    generate
        if (MAN_W >= 64) begin : g_wide
            if (MAN_W > 64) begin : g_pad
                assign pi_man = {PI_SIG, {(MAN_W - 64){1'b0}}};
            end else begin : g_exact
                assign pi_man = PI_SIG;
            end
        end else begin : g_narrow
            assign pi_man = PI_SIG[63 -: MAN_W];
        end
    endgenerate

    assign one_man = {1'b1, {(MAN_W - 1){1'b0}}};

    always_comb begin
        unique case (op_i)
            OP_PUSH_ONE: const_o = {1'b0, BIAS, one_man};
            OP_PUSH_PI:  const_o = {1'b0, BIAS + EXP_W'(1), pi_man};
            default:     const_o = '0;
        endcase
    end
endmodule

// File: rtl/fp_stack_rdmux.sv
module fp_stack_rdmux
    import fp_stack_pkg::*;
#(
    parameter int W     = FP_W,
    parameter int DEPTH = STK_DEPTH,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][W-1:0] regs_i,
    input  logic [DEPTH-1:0][1:0]   tags_i,
    input  logic [PTR_W-1:0]        top_i,
    input  logic [PTR_W-1:0]        idx_i,
    output logic [W-1:0]            data_o,
    output stk_tag_e                tag_o
);
    logic [PTR_W-1:0] phys;

    assign phys   = top_i + idx_i;
    assign data_o = regs_i[phys];
    assign tag_o  = stk_tag_e'(tags_i[phys]);
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack
    import fp_stack_pkg::*;
#(
    parameter int W     = FP_W,
    parameter int EXP_W = FP_EXP_W,
    parameter int DEPTH = STK_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           op,
    input  logic [W-1:0]         push_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]         rd_data,
    output logic [2*DEPTH-1:0]   tag_word,
    output logic [$clog2(DEPTH)-1:0] top_ptr,
    output logic                 stack_fault,
    output logic                 cond_c1,
    output logic [15:0]          status_word
);
    localparam int PTR_W    = $clog2(DEPTH);
    localparam int TOP_LSB  = 11;
    localparam int C1_BIT   = 9;
    localparam int SF_BIT   = 6;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] regs;
        logic [DEPTH-1:0][1:0]   tags;
        logic [PTR_W-1:0]        top;
        logic                    fault;
        logic                    c1;
    } stk_state_t;

    stk_state_t st_d, st_q;

    stk_op_e          op_e;
    logic [W-1:0]     const_val;
    logic [W-1:0]     push_val;
    stk_tag_e         push_tag;
    stk_tag_e         rd_tag;
    logic [PTR_W-1:0] tgt_d;
    logic             is_push;

    assign op_e = stk_op_e'(op);

    fp_preset_rom #(.W(W), .EXP_W(EXP_W)) i_rom (
        .op_i    (op_e),
        .const_o (const_val)
    );

    assign push_val = (op_e == OP_PUSH) ? push_data : const_val;

    fp_tag_classify #(.W(W), .EXP_W(EXP_W)) i_classify (
        .value_i (push_val),
        .tag_o   (push_tag)
    );

    fp_stack_rdmux #(.W(W), .DEPTH(DEPTH), .PTR_W(PTR_W)) i_rdmux (
        .regs_i (st_q.regs),
        .tags_i (st_q.tags),
        .top_i  (st_q.top),
        .idx_i  (rd_idx),
        .data_o (rd_data),
        .tag_o  (rd_tag)
    );

    assign tgt_d   = st_q.top - PTR_W'(1);
    assign is_push = (op_e == OP_PUSH) || (op_e == OP_PUSH_ONE) ||
                     (op_e == OP_PUSH_PI) || (op_e == OP_PUSH_ZERO);

    always_comb begin
        st_d = st_q;
        if (is_push) begin
            if (stk_tag_e'(st_q.tags[tgt_d]) != TAG_EMPTY) begin
                st_d.fault = 1'b1;
                st_d.c1    = 1'b1;
            end else begin
                st_d.regs[tgt_d] = push_val;
                st_d.tags[tgt_d] = push_tag;
                st_d.top         = tgt_d;
            end
        end else begin
            unique case (op_e)
                OP_CLEAR: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        st_d.tags[i] = TAG_EMPTY;
                    end
                    st_d.top   = '0;
                    st_d.fault = 1'b0;
                    st_d.c1    = 1'b0;
                end
                OP_POP: begin
                    if (stk_tag_e'(st_q.tags[st_q.top]) == TAG_EMPTY) begin
                        st_d.fault = 1'b1;
                        st_d.c1    = 1'b0;
                    end else begin
                        st_d.tags[st_q.top] = TAG_EMPTY;
                        st_d.top            = st_q.top + PTR_W'(1);
                    end
                end
                OP_READ: begin
                    if (rd_tag == TAG_EMPTY) begin
                        st_d.fault = 1'b1;
                        st_d.c1    = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs  <= '0;
            st_q.tags  <= '1;
            st_q.top   <= '0;
            st_q.fault <= 1'b0;
            st_q.c1    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_tagword
            assign tag_word[2*g +: 2] = st_q.tags[g];
        end
    endgenerate

    assign top_ptr     = st_q.top;
    assign stack_fault = st_q.fault;
    assign cond_c1     = st_q.c1;

    always_comb begin
        status_word                      = '0;
        status_word[TOP_LSB +: PTR_W]    = st_q.top;
        status_word[C1_BIT]              = st_q.c1;
        status_word[SF_BIT]              = st_q.fault;
    end
endmodule

// File: rtl/fp_reg_stack_chk.sv
module fp_reg_stack_chk #(
    parameter int W     = 80,
    parameter int DEPTH = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [2:0]               op,
    input logic [$clog2(DEPTH)-1:0] rd_idx,
    input logic [2*DEPTH-1:0]       tag_word,
    input logic [$clog2(DEPTH)-1:0] top_ptr,
    input logic                     stack_fault,
    input logic                     cond_c1,
    input logic [15:0]              status_word
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0] below_top;
    logic [PTR_W-1:0] rd_slot;
    logic             below_empty;
    logic             top_empty;
    logic             slot_empty;
    logic             push_op;

    assign below_top   = top_ptr - PTR_W'(1);
    assign rd_slot     = top_ptr + rd_idx;
    assign below_empty = (tag_word[2*below_top +: 2] == 2'b11);
    assign top_empty   = (tag_word[2*top_ptr +: 2] == 2'b11);
    assign slot_empty  = (tag_word[2*rd_slot +: 2] == 2'b11);
    assign push_op     = (op >= 3'd2) && (op <= 3'd5);

    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        op == 3'd1 |=> (&tag_word) && top_ptr == '0 && !stack_fault && !cond_c1);

    a_r5_push_moves_top: assert property (@(posedge clk) disable iff (!rst_n)
        push_op && below_empty |=> top_ptr == $past(below_top) && !$stable(tag_word));

    a_r8_push_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_op && !below_empty |=> stack_fault && cond_c1 && $stable(top_ptr) && $stable(tag_word));

    a_r9_pop_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        op == 3'd6 && top_empty |=> stack_fault && !cond_c1 && $stable(top_ptr));

    a_r10_read_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        op == 3'd7 && slot_empty |=> stack_fault && !cond_c1 && $stable(tag_word));

    a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_fault && op != 3'd1 |=> stack_fault);

    a_r12_nop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        op == 3'd0 |=> $stable(tag_word) && $stable(top_ptr) && $stable(stack_fault));

    a_r2_status_fields: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[13:11] == top_ptr && status_word[6] == stack_fault &&
        status_word[9] == cond_c1);
endmodule

bind fp_reg_stack fp_reg_stack_chk #(.W(W), .DEPTH(DEPTH)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .rd_idx      (rd_idx),
    .tag_word    (tag_word),
    .top_ptr     (top_ptr),
    .stack_fault (stack_fault),
    .cond_c1     (cond_c1),
    .status_word (status_word)
);

// File: tb/test_fp_reg_stack.sv
module test_fp_reg_stack;
    localparam logic [79:0] K_ONE = 80'h3FFF8000000000000000;
    localparam logic [79:0] K_PI  = 80'h4000C90FDAA22168C235;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [79:0] push_data = '0;
    logic [2:0]  rd_idx = 3'd0;
    logic [79:0] rd_data;
    logic [15:0] tag_word;
    logic [2:0]  top_ptr;
    logic        stack_fault;
    logic        cond_c1;
    logic [15:0] status_word;

    always #10 clk = ~clk;

    fp_reg_stack i_fp_reg_stack (
        .clk(clk), .rst_n(rst_n), .op(op), .push_data(push_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .tag_word(tag_word),
        .top_ptr(top_ptr), .stack_fault(stack_fault), .cond_c1(cond_c1),
        .status_word(status_word)
    );

    logic [79:0] m_reg [8];
    int          m_tag [8];
    int          m_top;
    bit          m_fault, m_c1;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 0;

    task automatic cmp(string req, string what, logic [79:0] act, logic [79:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        logic [15:0] tw = '0;
        logic [15:0] sw;
        for (int i = 0; i < 8; i++) tw[2*i +: 2] = 2'(m_tag[i]);
        sw = (16'(m_top) << 11) | (16'(m_c1) << 9) | (16'(m_fault) << 6);
        cmp(req, "rd_data(R10)", rd_data, m_reg[(m_top + int'(rd_idx)) % 8]);
        cmp(req, "tag_word(R4)", 80'(tag_word), 80'(tw));
        cmp(req, "top_ptr", 80'(top_ptr), 80'(m_top));
        cmp(req, "stack_fault", 80'(stack_fault), 80'(m_fault));
        cmp(req, "cond_c1", 80'(cond_c1), 80'(m_c1));
        cmp(req, "status_word(R2)", 80'(status_word), 80'(sw));
    endtask

    // exp_tag: tag the requirements assign to the value being pushed
    task automatic apply(string req, int code, logic [79:0] data, int idx, int exp_tag);
        int t;
        logic [79:0] val;
        op = 3'(code);
        push_data = data;
        rd_idx = 3'(idx);
        @(posedge clk);
        case (code)
            1: begin
                for (int i = 0; i < 8; i++) m_tag[i] = 3;
                m_top = 0; m_fault = 0; m_c1 = 0;
            end
            2, 3, 4, 5: begin
                val = (code == 2) ? data : (code == 3) ? K_ONE : (code == 4) ? K_PI : '0;
                t = (m_top + 7) % 8;
                if (m_tag[t] != 3) begin
                    m_fault = 1; m_c1 = 1;
                end else begin
                    m_reg[t] = val; m_tag[t] = exp_tag; m_top = t;
                end
            end
            6: begin
                if (m_tag[m_top] == 3) begin
                    m_fault = 1; m_c1 = 0;
                end else begin
                    m_tag[m_top] = 3; m_top = (m_top + 1) % 8;
                end
            end
            7: begin
                if (m_tag[(m_top + idx) % 8] == 3) begin
                    m_fault = 1; m_c1 = 0;
                end
            end
            default: ;
        endcase
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_reg[i] = '0; m_tag[i] = 3;
        end
        m_top = 0; m_fault = 0; m_c1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");
        apply("R12 nop", 0, 80'hDEAD, 3, 0);
        // R7 presets, R5 first push lands in physical 7
        apply("R7 R5 push one", 3, '0, 0, 0);
        apply("R7 push pi", 4, '0, 0, 0);
        apply("R7 push zero", 5, '0, 1, 1);
        // R6 classification of external values
        apply("R6 valid", 2, 80'hC005_A000000000000001, 0, 0);
        apply("R6 infinity special", 2, 80'h7FFF_8000000000000000, 0, 2);
        apply("R6 denormal special", 2, 80'h0000_0000000000000001, 0, 2);
        apply("R6 unnormal special", 2, 80'h1234_7FFFFFFFFFFFFFFF, 0, 2);
        apply("R6 negative zero", 2, 80'h8000_0000000000000000, 0, 1);
        // R8 ninth push into full stack
        apply("R8 overflow push", 2, 80'h4001_8000000000000000, 0, 0);
        apply("R8 overflow preset", 4, '0, 2, 0);
        for (int i = 0; i < 8; i++) apply("R10 read full", 7, '0, i, 0);
        // R9 pop everything, then underflow; R11 fault kept, C1 flips
        for (int i = 0; i < 8; i++) apply("R9 pop", 6, '0, 0, 0);
        apply("R9 R11 pop empty", 6, '0, 0, 0);
        apply("R3 clear", 1, '0, 0, 0);
        for (int i = 0; i < 8; i++) apply("R3 data kept", 0, '0, i, 0);
        apply("R10 read empty", 7, '0, 5, 0);
        apply("R11 sticky", 0, '0, 0, 0);
        apply("R11 sticky push", 3, '0, 0, 0);
        apply("R3 clear again", 1, '0, 0, 0);
        apply("R5 push", 2, 80'h3FFE_C000000000000000, 0, 0);
        apply("R10 read ok", 7, '0, 0, 0);
        apply("R9 pop", 6, '0, 0, 0);
        apply("R9 pop empty", 6, '0, 0, 0);
        apply("R1 rst", 0, '0, 0, 0);
        rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            m_reg[i] = '0; m_tag[i] = 3;
        end
        m_top = 0; m_fault = 0; m_c1 = 0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset again");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule